// File: doc/BRIEF.md
# Paged Flash Window Decoder

This block connects a byte-wide host bus of the classic PC expansion kind to one 8-bit parallel flash device of up to 16 MiB. The host sees the flash through a fixed 16 KiB memory window. A page register made of two adjacent I/O bytes picks which 16 KiB slice of the flash appears in that window. The block decodes host memory and I/O cycles and keeps the page register. It forms the 24-bit flash address by placing the page bits above the window offset. It drives the flash chip-enable, output-enable, write-enable and reset/power-down lines, and it answers I/O reads of the page register.

Host software selects a page once. It can then run any number of window reads and writes without touching the page again. Flash command sequences, device probing, partitioning and splitting transfers at window edges stay in host software.

The upper page byte carries a device-enable flag. While that flag is clear the flash is held in reset/power-down and window cycles do not reach the flash at all. After system reset the flag is clear.

Top module: `pgwin_flash_bridge`

## Requirements
- R1: After reset both page bytes are zero, `flash_rst_n` is 0, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are 1, and `host_rdata_oe` is 0.
- R2: A host memory read at 0xDC000..0xDFFFF with the enable flag set gives, from the next clock edge, `flash_ce_n`=0, `flash_oe_n`=0, `flash_we_n`=1 and `flash_addr` = {page high bits, page low byte, host_addr[13:0]}. During that cycle `host_rdata_oe`=1 and `host_rdata` = {8'h00, flash_dq_in}.
- R3: A host memory write in the window with the enable flag set gives, from the next edge, `flash_ce_n`=0, `flash_we_n`=0, `flash_oe_n`=1, `flash_dq_oe`=1 and `flash_dq_out` = host_wdata[7:0]. Output-enable and write-enable are never low together.
- R4: A byte I/O write to 0x258 stores host_wdata[7:0] as flash address bits 21:14.
- R5: A byte I/O write to 0x259 stores host_wdata[1:0] as flash address bits 23:22 and host_wdata[7] as the enable flag. Bits 6:2 are discarded.
- R6: A 16-bit I/O write (`host_io_wide`=1) to 0x258 updates both bytes in one cycle: low byte from host_wdata[7:0], upper byte from host_wdata[15:8] with the R5 field positions.
- R7: `flash_rst_n` follows the enable flag. While the flag is 0, window cycles leave `flash_ce_n`, `flash_oe_n` and `flash_we_n` at 1 and the host bus undriven.
- R8: An I/O read of 0x258 returns {8'h00, low byte}. A read of 0x259 returns {8'h00, enable, 5'b0, high bits}. A 16-bit read of 0x258 returns {upper byte, low byte}. Every I/O read drives `host_rdata_oe`=1.
- R9: The page bytes and the enable flag change only on an I/O write to 0x258 or 0x259. Window reads and writes leave them unchanged.
- R10: Cycles outside the window and the two I/O bytes leave every flash strobe inactive and `host_rdata_oe`=0, and they change no page state. Whenever `host_rdata_oe` is 0, `host_rdata` reads 16'hFFFF, as a pulled-up floating bus would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 20 | Host address (I/O cycles use bits 15:0) |
| host_mem_rd | input | 1 | Memory read strobe, active high |
| host_mem_wr | input | 1 | Memory write strobe, active high |
| host_io_rd | input | 1 | I/O read strobe, active high |
| host_io_wr | input | 1 | I/O write strobe, active high |
| host_io_wide | input | 1 | I/O cycle is 16 bits wide |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_oe | output | 1 | Block drives the host data bus |
| flash_addr | output | 24 | Flash byte address |
| flash_dq_in | input | 8 | Data from flash |
| flash_dq_out | output | 8 | Data to flash |
| flash_dq_oe | output | 1 | Block drives the flash data bus |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_rst_n | output | 1 | Flash reset/power-down, active low |

## Verification
The assertions check four properties on every cycle. Output-enable and write-enable are never low together. Chip-enable is never low while the flash is in reset or when neither strobe is active. The page bits and the reset line stay stable whenever no I/O write happened the cycle before. The floating-bus value of 0xFFFF shows whenever the host bus is released. Only the bench scenarios can show the rest: that each page byte lands on its own flash address bits, that bits 6:2 of the upper byte are dropped, that a 16-bit write updates both bytes at once, that readback returns the exact page values, and that disabled or out-of-range cycles keep the flash quiet.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

    // Classified host cycle for one clock.
    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_MRD,
        ACC_MWR,
        ACC_IORD_LO,
        ACC_IORD_HI,
        ACC_IORD_W,
        ACC_IOWR_LO,
        ACC_IOWR_HI,
        ACC_IOWR_W
    } acc_e;

    // Source of the host read data in the current cycle.
    typedef enum logic [2:0] {
        RS_NONE,
        RS_FLASH,
        RS_PG_LO,
        RS_PG_HI,
        RS_PG_W
    } rsel_e;

endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
    import pgwin_pkg::*;
#(
    parameter int                  HOST_AW  = 20,
    parameter int                  WIN_AW   = 14,
    parameter logic [HOST_AW-1:0]  WIN_BASE = 20'hDC000,
    parameter int                  IO_AW    = 16,
    parameter logic [IO_AW-1:0]    IO_BASE  = 16'h0258
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_mem_rd,
    input  logic               host_mem_wr,
    input  logic               host_io_rd,
    input  logic               host_io_wr,
    input  logic               host_io_wide,
    output acc_e               acc
);
    localparam int                TAG_W  = HOST_AW - WIN_AW;
    localparam logic [TAG_W-1:0]  WIN_TAG = WIN_BASE[HOST_AW-1:WIN_AW];
    localparam logic [IO_AW-1:0]  IO_HI   = IO_AW'(IO_BASE + 1);

    logic in_win;
    logic hit_lo;
    logic hit_hi;

    always_comb begin
        in_win = (host_addr[HOST_AW-1:WIN_AW] == WIN_TAG);
        hit_lo = (host_addr[IO_AW-1:0] == IO_BASE);
        hit_hi = (host_addr[IO_AW-1:0] == IO_HI);
        acc    = ACC_NONE;
        // Write strobes win over read strobes; memory wins over I/O.
        if (host_mem_wr) begin
            if (in_win) acc = ACC_MWR;
        end else if (host_mem_rd) begin
            if (in_win) acc = ACC_MRD;
        end else if (host_io_wr) begin
            if (hit_lo)      acc = host_io_wide ? ACC_IOWR_W : ACC_IOWR_LO;
            else if (hit_hi) acc = ACC_IOWR_HI;
        end else if (host_io_rd) begin
            if (hit_lo)      acc = host_io_wide ? ACC_IORD_W : ACC_IORD_LO;
            else if (hit_hi) acc = ACC_IORD_HI;
        end
    end
endmodule

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg
    import pgwin_pkg::*;
#(
    parameter int LO_W   = 8,
    parameter int HI_W   = 2,
    parameter int EN_BIT = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_e            acc,
    input  logic [15:0]     host_wdata,
    output logic [LO_W-1:0] page_lo,
    output logic [HI_W-1:0] page_hi,
    output logic            dev_en
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        logic            en;
    } page_t;

    page_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        case (acc)
            ACC_IOWR_LO: pg_d.lo = host_wdata[LO_W-1:0];
            ACC_IOWR_HI: begin
                pg_d.hi = host_wdata[HI_W-1:0];
                pg_d.en = host_wdata[EN_BIT];
            end
            ACC_IOWR_W: begin
                pg_d.lo = host_wdata[LO_W-1:0];
                pg_d.hi = host_wdata[8 +: HI_W];
                pg_d.en = host_wdata[8 + EN_BIT];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign page_lo = pg_q.lo;
    assign page_hi = pg_q.hi;
    assign dev_en  = pg_q.en;
endmodule

// File: rtl/pgwin_bus_ctrl.sv
module pgwin_bus_ctrl
    import pgwin_pkg::*;
#(
    parameter int WIN_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic              dev_en,
    input  logic [WIN_AW-1:0] win_off,
    input  logic [7:0]        host_wdata_lo,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [7:0]        dq_out,
    output logic [WIN_AW-1:0] off,
    output rsel_e             rsel
);
    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic [7:0]        dq;
        logic [WIN_AW-1:0] off;
        rsel_e             rsel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ce_n  = 1'b1;
        ctl_d.oe_n  = 1'b1;
        ctl_d.we_n  = 1'b1;
        ctl_d.dq_oe = 1'b0;
        ctl_d.rsel  = RS_NONE;
        case (acc)
            ACC_MRD: if (dev_en) begin
                ctl_d.ce_n = 1'b0;
                ctl_d.oe_n = 1'b0;
                ctl_d.off  = win_off;
                ctl_d.rsel = RS_FLASH;
            end
            ACC_MWR: if (dev_en) begin
                ctl_d.ce_n  = 1'b0;
                ctl_d.we_n  = 1'b0;
                ctl_d.dq_oe = 1'b1;
                ctl_d.dq    = host_wdata_lo;
                ctl_d.off   = win_off;
            end
            ACC_IORD_LO: ctl_d.rsel = RS_PG_LO;
            ACC_IORD_HI: ctl_d.rsel = RS_PG_HI;
            ACC_IORD_W:  ctl_d.rsel = RS_PG_W;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.ce_n <= 1'b1;
            ctl_q.oe_n <= 1'b1;
            ctl_q.we_n <= 1'b1;
            ctl_q.rsel <= RS_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ce_n   = ctl_q.ce_n;
    assign oe_n   = ctl_q.oe_n;
    assign we_n   = ctl_q.we_n;
    assign dq_oe  = ctl_q.dq_oe;
    assign dq_out = ctl_q.dq;
    assign off    = ctl_q.off;
    assign rsel   = ctl_q.rsel;
endmodule

// File: rtl/pgwin_flash_bridge.sv
module pgwin_flash_bridge
    import pgwin_pkg::*;
#(
    parameter int                  HOST_AW  = 20,
    parameter int                  WIN_AW   = 14,
    parameter logic [HOST_AW-1:0]  WIN_BASE = 20'hDC000,
    parameter int                  IO_AW    = 16,
    parameter logic [IO_AW-1:0]    IO_BASE  = 16'h0258,
    parameter int                  FLASH_AW = 24,
    parameter int                  PAGE_LO_W = 8,
    parameter int                  EN_BIT   = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic                host_mem_rd,
    input  logic                host_mem_wr,
    input  logic                host_io_rd,
    input  logic                host_io_wr,
    input  logic                host_io_wide,
    input  logic [15:0]         host_wdata,
    output logic [15:0]         host_rdata,
    output logic                host_rdata_oe,
    output logic [FLASH_AW-1:0] flash_addr,
    input  logic [7:0]          flash_dq_in,
    output logic [7:0]          flash_dq_out,
    output logic                flash_dq_oe,
    output logic                flash_ce_n,
    output logic                flash_oe_n,
    output logic                flash_we_n,
    output logic                flash_rst_n
);
    localparam int PAGE_HI_W = FLASH_AW - WIN_AW - PAGE_LO_W;

    acc_e                 acc;
    logic [PAGE_LO_W-1:0] page_lo;
    logic [PAGE_HI_W-1:0] page_hi;
    logic                 dev_en;
    logic [WIN_AW-1:0]    off;
    rsel_e                rsel;
    logic [7:0]           hi_byte;

    pgwin_decode #(
        .HOST_AW (HOST_AW),
        .WIN_AW  (WIN_AW),
        .WIN_BASE(WIN_BASE),
        .IO_AW   (IO_AW),
        .IO_BASE (IO_BASE)
    ) u_decode (
        .host_addr   (host_addr),
        .host_mem_rd (host_mem_rd),
        .host_mem_wr (host_mem_wr),
        .host_io_rd  (host_io_rd),
        .host_io_wr  (host_io_wr),
        .host_io_wide(host_io_wide),
        .acc         (acc)
    );

    pgwin_page_reg #(
        .LO_W  (PAGE_LO_W),
        .HI_W  (PAGE_HI_W),
        .EN_BIT(EN_BIT)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .host_wdata(host_wdata),
        .page_lo   (page_lo),
        .page_hi   (page_hi),
        .dev_en    (dev_en)
    );

    pgwin_bus_ctrl #(
        .WIN_AW(WIN_AW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .dev_en       (dev_en),
        .win_off      (host_addr[WIN_AW-1:0]),
        .host_wdata_lo(host_wdata[7:0]),
        .ce_n         (flash_ce_n),
        .oe_n         (flash_oe_n),
        .we_n         (flash_we_n),
        .dq_oe        (flash_dq_oe),
        .dq_out       (flash_dq_out),
        .off          (off),
        .rsel         (rsel)
    );

    // Readback image of the upper page byte: unused bits read zero.
    always_comb begin
        hi_byte                  = '0;
        hi_byte[PAGE_HI_W-1:0]   = page_hi;
        hi_byte[EN_BIT]          = dev_en;
    end

    always_comb begin
        host_rdata_oe = (rsel != RS_NONE);
        case (rsel)
            RS_FLASH: host_rdata = {8'h00, flash_dq_in};
            RS_PG_LO: host_rdata = {8'h00, page_lo};
            RS_PG_HI: host_rdata = {8'h00, hi_byte};
            RS_PG_W:  host_rdata = {hi_byte, page_lo};
            default:  host_rdata = 16'hFFFF;
        endcase
    end

    assign flash_addr  = {page_hi, page_lo, off};
    assign flash_rst_n = dev_en;
endmodule

// File: rtl/pgwin_flash_bridge_chk.sv
module pgwin_flash_bridge_chk #(
    parameter int FLASH_AW = 24,
    parameter int WIN_AW   = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_io_wr,
    input logic [FLASH_AW-1:0] flash_addr,
    input logic                flash_ce_n,
    input logic                flash_oe_n,
    input logic                flash_we_n,
    input logic                flash_rst_n,
    input logic                flash_dq_oe,
    input logic                host_rdata_oe,
    input logic [15:0]         host_rdata
);
    // R3
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_oe_n && !flash_we_n));

    // R3
    dq_drive_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_dq_oe |-> !flash_we_n);

    // R2
    ce_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_ce_n |-> (!flash_oe_n || !flash_we_n));

    // R7
    ce_quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n |-> flash_ce_n);

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_io_wr |=> ($stable(flash_addr[FLASH_AW-1:WIN_AW]) && $stable(flash_rst_n)));

    // R10
    float_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata_oe |-> (host_rdata == 16'hFFFF));
endmodule

bind pgwin_flash_bridge pgwin_flash_bridge_chk #(
    .FLASH_AW(FLASH_AW),
    .WIN_AW  (WIN_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_io_wr   (host_io_wr),
    .flash_addr   (flash_addr),
    .flash_ce_n   (flash_ce_n),
    .flash_oe_n   (flash_oe_n),
    .flash_we_n   (flash_we_n),
    .flash_rst_n  (flash_rst_n),
    .flash_dq_oe  (flash_dq_oe),
    .host_rdata_oe(host_rdata_oe),
    .host_rdata   (host_rdata)
);

// File: tb/tb_pgwin_flash_bridge.sv
module tb_pgwin_flash_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic        host_mem_rd = 1'b0, host_mem_wr = 1'b0;
    logic        host_io_rd = 1'b0, host_io_wr = 1'b0, host_io_wide = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rdata_oe;
    logic [23:0] flash_addr;
    logic [7:0]  flash_dq_in;
    logic [7:0]  flash_dq_out;
    logic        flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n, flash_rst_n;

    always #4 clk = ~clk;   // 125 MHz

    pgwin_flash_bridge dut (.*);

    function automatic logic [7:0] fl_hash(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    // Simple flash data model
    assign flash_dq_in = flash_oe_n ? 8'h00 : fl_hash(flash_addr);

    typedef struct {
        int          due;
        string       req;
        logic        ce_n, oe_n, we_n, rst_n, dq_oe, rd_oe;
        logic [23:0] addr;
        logic [7:0]  dq;
        logic [15:0] rdata;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Model of page state, from the requirements
    logic [7:0] m_lo = 8'h00;
    logic [1:0] m_hi = 2'b00;
    logic       m_en = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares items when they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "ce_n",  24'(flash_ce_n),  24'(e.ce_n));
            chk(e.req, "oe_n",  24'(flash_oe_n),  24'(e.oe_n));
            chk(e.req, "we_n",  24'(flash_we_n),  24'(e.we_n));
            chk(e.req, "rst_n", 24'(flash_rst_n), 24'(e.rst_n));
            chk(e.req, "dq_oe", 24'(flash_dq_oe), 24'(e.dq_oe));
            chk(e.req, "rd_oe", 24'(host_rdata_oe), 24'(e.rd_oe));
            chk(e.req, "rdata", 24'(host_rdata),  24'(e.rdata));
            chk(e.req, "page_bits", 24'(flash_addr[23:14]), 24'({m_hi, m_lo}) & 24'h0 | 24'(e.addr[23:14]));
            if (!e.ce_n)  chk(e.req, "addr", flash_addr, e.addr);
            if (e.dq_oe)  chk(e.req, "dq_out", 24'(flash_dq_out), 24'(e.dq));
        end
    end

    function automatic exp_t base_exp(input string req);
        exp_t e;
        e.due = cyc + 1; e.req = req;
        e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.rst_n = m_en;
        e.dq_oe = 0; e.rd_oe = 0; e.rdata = 16'hFFFF; e.dq = 8'h00;
        e.addr = {m_hi, m_lo, 14'h0};
        return e;
    endfunction

    task automatic clr_strobes();
        host_mem_rd = 0; host_mem_wr = 0; host_io_rd = 0; host_io_wr = 0; host_io_wide = 0;
    endtask

    function automatic bit in_win(input logic [19:0] a);
        return a[19:14] == 6'b110111;
    endfunction

    task automatic idle(input string req);
        @(negedge clk);
        clr_strobes();
        q.push_back(base_exp(req));
    endtask

    task automatic mem_rd(input logic [19:0] a, input string req);
        exp_t e;
        @(negedge clk);
        clr_strobes(); host_addr = a; host_mem_rd = 1;
        e = base_exp(req);
        if (in_win(a) && m_en) begin
            e.ce_n = 0; e.oe_n = 0; e.rd_oe = 1;
            e.addr = {m_hi, m_lo, a[13:0]};
            e.rdata = {8'h00, fl_hash(e.addr)};
        end
        q.push_back(e);
    endtask

    task automatic mem_wr(input logic [19:0] a, input logic [7:0] d, input string req);
        exp_t e;
        @(negedge clk);
        clr_strobes(); host_addr = a; host_wdata = {8'hC3, d}; host_mem_wr = 1;
        e = base_exp(req);
        if (in_win(a) && m_en) begin
            e.ce_n = 0; e.we_n = 0; e.dq_oe = 1; e.dq = d;
            e.addr = {m_hi, m_lo, a[13:0]};
        end
        q.push_back(e);
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [15:0] d, input bit wide, input string req);
        @(negedge clk);
        clr_strobes(); host_addr = {4'h0, a}; host_wdata = d; host_io_wr = 1; host_io_wide = wide;
        if (a == 16'h0258) begin
            m_lo = d[7:0];
            if (wide) begin m_hi = d[9:8]; m_en = d[15]; end
        end else if (a == 16'h0259) begin
            m_hi = d[1:0]; m_en = d[7];
        end
        q.push_back(base_exp(req));
    endtask

    task automatic io_rd(input logic [15:0] a, input bit wide, input string req);
        exp_t e;
        logic [7:0] hb;
        @(negedge clk);
        clr_strobes(); host_addr = {4'h0, a}; host_io_rd = 1; host_io_wide = wide;
        e = base_exp(req);
        hb = {m_en, 5'b0, m_hi};
        if (a == 16'h0258) begin
            e.rd_oe = 1; e.rdata = wide ? {hb, m_lo} : {8'h00, m_lo};
        end else if (a == 16'h0259) begin
            e.rd_oe = 1; e.rdata = {8'h00, hb};
        end
        q.push_back(e);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "rst_n", 24'(flash_rst_n), 24'h0);
        chk("R1", "ce_n",  24'(flash_ce_n), 24'h1);
        chk("R1", "oe_we", 24'({flash_oe_n, flash_we_n}), 24'h3);
        chk("R1", "rd_oe", 24'(host_rdata_oe), 24'h0);
        rst_n = 1;
        io_rd(16'h0258, 1, "R1");

        // R7: disabled flash ignores window cycles
        mem_rd(20'hDC010, "R7");
        mem_wr(20'hDC020, 8'hAA, "R7");

        // R5: upper byte, bits 6:2 discarded
        io_wr(16'h0259, 16'h00FE, 0, "R5");
        io_rd(16'h0259, 0, "R5");
        // R4: low byte
        io_wr(16'h0258, 16'h00A5, 0, "R4");
        io_rd(16'h0258, 0, "R4");
        io_rd(16'h0258, 1, "R8");

        // R2 / R3: window accesses
        mem_rd(20'hDC000, "R2");
        mem_rd(20'hDFFFF, "R2");
        mem_rd(20'hDD234, "R2");
        mem_wr(20'hDE001, 8'h3C, "R3");
        mem_wr(20'hDFFFE, 8'hFF, "R3");
        mem_rd(20'hDC7FF, "R9");
        idle("R3");

        // R10: outside ranges
        mem_rd(20'hDBFFF, "R10");
        mem_wr(20'hE0000, 8'h11, "R10");
        io_wr(16'h0257, 16'hFFFF, 1, "R10");
        io_wr(16'h025A, 16'h0000, 0, "R10");
        io_rd(16'h0260, 0, "R10");
        io_rd(16'h0258, 1, "R9");

        // R6: 16-bit write updates both bytes
        io_wr(16'h0258, 16'h8142, 1, "R6");
        io_rd(16'h0258, 1, "R6");
        mem_rd(20'hDC123, "R6");
        io_wr(16'h0258, 16'h7F0F, 1, "R6");
        io_rd(16'h0259, 1, "R8");
        mem_rd(20'hDC123, "R7");
        io_wr(16'h0259, 16'h0083, 0, "R5");
        mem_wr(20'hDFFFF, 8'h96, "R3");
        mem_rd(20'hDC001, "R2");
        idle("R9");
        idle("R9");
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule